// File: doc/BRIEF.md
# Integer Execute Unit with Condition Flags

This block is the arithmetic and logic stage of a simple integer pipeline. Each operation is issued with a one-cycle `start` pulse that carries a 4-bit operation code, two register operands, an immediate, a third operand used only by multiply-subtract, and a request to update the condition flags. It covers add, subtract, multiply, multiply-subtract, the four bitwise operations (AND, OR, XOR, and AND with an inverted operand), left and right logical shifts, right rotation, and both unsigned and signed division.

All operations except division finish in one cycle. Division uses a restoring divider that produces one quotient bit per clock, so it takes WIDTH cycles. During that time `busy` is high and any new `start` is dropped. Each finished operation is marked by a single-cycle `done` pulse, and `result` keeps its value until the next completion. The four condition flags are held in a register. That register changes only for the flag-setting forms of add, subtract and AND. Decode, register storage and memory access belong to neighbouring blocks.

Top module: `int_exec_unit`

## Requirements
- R1: Operand 2 is `imm` when `use_imm` is 1 and `op_b` otherwise, for every operation. Opcode 0 (add) returns op_a + operand2 modulo 2^WIDTH. Opcode 1 (subtract) returns op_a − operand2 modulo 2^WIDTH.
- R2: Opcode 2 (multiply) returns the low WIDTH bits of op_a × operand2. Opcode 3 (multiply-subtract) returns the low WIDTH bits of op_a − operand2 × op_c.
- R3: Opcodes 4, 5 and 6 return the bitwise AND, OR and XOR of op_a and operand2. Opcode 7 (bit-clear) returns op_a AND NOT operand2.
- R4: The shift amount is the low log2(WIDTH) bits of operand2. Opcode 8 shifts op_a left and opcode 9 shifts it right, both filling with zeros. Opcode 10 rotates op_a right, with the bits leaving the bottom entering at the top.
- R5: Opcode 11 returns the unsigned quotient of op_a / operand2. When the divisor is 0, the quotient is 0.
- R6: Opcode 12 returns the signed quotient of op_a / operand2, rounded toward zero. When the divisor is 0, the quotient is 0. The most negative value divided by −1 returns the most negative value.
- R7: For a non-divide operation, `result` and a one-cycle `done` appear right after the clock edge that samples `start`. For a divide, `busy` is high for WIDTH cycles. `done` pulses for one cycle, WIDTH edges after the sampling edge, with `busy` low in that cycle. `result` changes only in a `done` cycle.
- R8: A `start` that arrives while `busy` is high is ignored. It changes neither the result, the timing of `done`, nor the flags.
- R9: For opcode 0 or 1 with `set_flags` = 1, the flags are updated as follows. N is result bit WIDTH−1 and Z is 1 when the result is 0. For add, C is the carry out. For subtract, C is 1 when op_a ≥ operand2 as unsigned values. V is set on signed overflow.
- R10: For opcode 4 with `set_flags` = 1, N and Z are updated from the result, and C and V keep their previous values.
- R11: Every other case leaves all four flags unchanged. This covers `set_flags` = 0, any other opcode, and divides.
- R12: After reset, `result`, `busy`, `done` and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Issue pulse for the operation on the input pins |
| opcode | input | 4 | Operation code |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second register operand |
| op_c | input | WIDTH | Multiplier operand for multiply-subtract |
| imm | input | WIDTH | Immediate second operand |
| use_imm | input | 1 | Selects `imm` as operand 2 |
| set_flags | input | 1 | Requests a flag update |
| result | output | WIDTH | Result of the last completed operation |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle completion pulse |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / no-borrow flag |
| flag_v | output | 1 | Signed overflow flag |

## Verification
Non-divide results, `done` and flag updates are registered once, so they are due at the first falling edge after the edge that samples `start`. The bench drives inputs on falling edges and checks at exactly that point. A division result is due WIDTH rising edges after the sampling edge. The bench counts falling edges until `done`, requires that count to equal WIDTH, and checks that `done` has fallen again one edge later. For an ignored `start`, the bench checks that `done` stays low on the cycle the add would have completed, and checks the flags when the division ends.

// File: rtl/int_exec_pkg.sv
`timescale 1ns/1ps
package int_exec_pkg;
   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_MUL  = 4'd2,
      OP_MLS  = 4'd3,
      OP_AND  = 4'd4,
      OP_OR   = 4'd5,
      OP_XOR  = 4'd6,
      OP_BIC  = 4'd7,
      OP_SHL  = 4'd8,
      OP_SHR  = 4'd9,
      OP_ROR  = 4'd10,
      OP_UDIV = 4'd11,
      OP_SDIV = 4'd12
   } exec_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } cond_flags_t;
endpackage

// File: rtl/alu_shifter.sv
`timescale 1ns/1ps
module alu_shifter #(
   parameter int W  = 32,
   localparam int SW = $clog2(W)
) (
   input  logic [W-1:0]  val,
   input  logic [SW-1:0] amt,
   input  logic          left,
   input  logic          rotate,
   output logic [W-1:0]  res
);
   logic [W-1:0] val_rev;
   logic [W-1:0] out_rev;
   logic [W-1:0] stage [0:SW];

   // left shift = right shift on the bit-reversed word
   for (genvar i = 0; i < W; i++) begin : g_rev
      assign val_rev[i] = val[W-1-i];
      assign out_rev[i] = stage[SW][W-1-i];
   end

   assign stage[0] = left ? val_rev : val;

   for (genvar s = 0; s < SW; s++) begin : g_stage
      localparam int D = 1 << s;
      logic [W-1:0] moved;
      assign moved        = {(rotate ? stage[s][D-1:0] : {D{1'b0}}), stage[s][W-1:D]};
      assign stage[s+1]   = amt[s] ? moved : stage[s];
   end

   assign res = left ? out_rev : stage[SW];
endmodule

// File: rtl/alu_comb.sv
`timescale 1ns/1ps
module alu_comb
   import int_exec_pkg::*;
#(
   parameter int W  = 32,
   localparam int SW = $clog2(W)
) (
   input  exec_op_e     op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] c,
   output logic [W-1:0] res,
   output logic         carry,
   output logic         ovf
);
   logic         is_sub;
   logic [W-1:0] b_eff;
   logic [W-1:0] sum;
   logic [W-1:0] m_lhs;
   logic [W-1:0] m_rhs;
   logic [W-1:0] prod;
   logic [W-1:0] shifted;

   // one adder serves add and subtract
   assign is_sub       = (op == OP_SUB);
   assign b_eff        = is_sub ? ~b : b;
   assign {carry, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
   assign ovf          = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);

   // one multiplier serves multiply and multiply-subtract
   assign m_lhs = (op == OP_MLS) ? b : a;
   assign m_rhs = (op == OP_MLS) ? c : b;
   assign prod  = m_lhs * m_rhs;

   alu_shifter #(.W(W)) u_shift (
      .val    (a),
      .amt    (b[SW-1:0]),
      .left   (op == OP_SHL),
      .rotate (op == OP_ROR),
      .res    (shifted)
   );

   always_comb begin
      case (op)
         OP_ADD, OP_SUB:         res = sum;
         OP_MUL:                 res = prod;
         OP_MLS:                 res = a - prod;
         OP_AND:                 res = a & b;
         OP_OR:                  res = a | b;
         OP_XOR:                 res = a ^ b;
         OP_BIC:                 res = a & ~b;
         OP_SHL, OP_SHR, OP_ROR: res = shifted;
         default:                res = '0;
      endcase
   end
endmodule

// File: rtl/alu_divider.sv
`timescale 1ns/1ps
module alu_divider #(
   parameter int W  = 32,
   localparam int CW = $clog2(W + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         is_signed,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic         busy,
   output logic         fin,
   output logic [W-1:0] quot
);
   logic [W-1:0]  rem_q;
   logic [W-1:0]  quo_q;
   logic [W-1:0]  dvs_q;
   logic [CW-1:0] cnt_q;
   logic          neg_q;
   logic          zero_q;

   logic [W:0]    trial;
   logic [W:0]    diff;
   logic          take;
   logic [W-1:0]  rem_n;
   logic [W-1:0]  quo_n;
   logic [W-1:0]  a_mag;
   logic [W-1:0]  b_mag;

   assign a_mag = (is_signed && dividend[W-1]) ? -dividend : dividend;
   assign b_mag = (is_signed && divisor[W-1])  ? -divisor  : divisor;

   // restoring step: shift in one dividend bit, keep the trial difference if non-negative
   assign trial = {rem_q, quo_q[W-1]};
   assign diff  = trial - {1'b0, dvs_q};
   assign take  = !diff[W];
   assign rem_n = take ? diff[W-1:0] : trial[W-1:0];
   assign quo_n = {quo_q[W-2:0], take};

   assign fin  = busy && (cnt_q == CW'(1));
   assign quot = zero_q ? '0 : (neg_q ? -quo_n : quo_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         quo_q  <= '0;
         dvs_q  <= '0;
         cnt_q  <= '0;
         neg_q  <= 1'b0;
         zero_q <= 1'b0;
         busy   <= 1'b0;
      end else if (load) begin
         rem_q  <= '0;
         quo_q  <= a_mag;
         dvs_q  <= b_mag;
         cnt_q  <= CW'(W);
         neg_q  <= is_signed && (dividend[W-1] ^ divisor[W-1]);
         zero_q <= (divisor == '0);
         busy   <= 1'b1;
      end else if (busy) begin
         rem_q  <= rem_n;
         quo_q  <= quo_n;
         cnt_q  <= cnt_q - CW'(1);
         busy   <= !fin;
      end
   end
endmodule

// File: rtl/int_exec_unit.sv
`timescale 1ns/1ps
module int_exec_unit
   import int_exec_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [3:0]       opcode,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [WIDTH-1:0] op_c,
   input  logic [WIDTH-1:0] imm,
   input  logic             use_imm,
   input  logic             set_flags,
   output logic [WIDTH-1:0] result,
   output logic             busy,
   output logic             done,
   output logic             flag_n,
   output logic             flag_z,
   output logic             flag_c,
   output logic             flag_v
);
   if (WIDTH < 4 || (WIDTH & (WIDTH - 1)) != 0) begin : g_width_bad
      $error("int_exec_unit: WIDTH must be a power of two of at least 4");
   end

   exec_op_e         op;
   logic [WIDTH-1:0] operand2;
   logic [WIDTH-1:0] alu_res;
   logic             alu_carry;
   logic             alu_ovf;
   logic             is_div;
   logic             accept;
   logic             div_busy;
   logic             div_fin;
   logic [WIDTH-1:0] div_quot;
   cond_flags_t      flags_q;

   assign op       = exec_op_e'(opcode);
   assign operand2 = use_imm ? imm : op_b;
   assign is_div   = (op == OP_UDIV) || (op == OP_SDIV);
   assign accept   = start && !div_busy;

   alu_comb #(.W(WIDTH)) u_comb (
      .op    (op),
      .a     (op_a),
      .b     (operand2),
      .c     (op_c),
      .res   (alu_res),
      .carry (alu_carry),
      .ovf   (alu_ovf)
   );

   alu_divider #(.W(WIDTH)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept && is_div),
      .is_signed (op == OP_SDIV),
      .dividend  (op_a),
      .divisor   (operand2),
      .busy      (div_busy),
      .fin       (div_fin),
      .quot      (div_quot)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result  <= '0;
         done    <= 1'b0;
         flags_q <= '0;
      end else begin
         done <= 1'b0;
         if (accept && !is_div) begin
            result <= alu_res;
            done   <= 1'b1;
            if (set_flags && (op == OP_ADD || op == OP_SUB || op == OP_AND)) begin
               flags_q.n <= alu_res[WIDTH-1];
               flags_q.z <= (alu_res == '0);
               if (op != OP_AND) begin
                  flags_q.c <= alu_carry;
                  flags_q.v <= alu_ovf;
               end
            end
         end else if (div_fin) begin
            result <= div_quot;
            done   <= 1'b1;
         end
      end
   end

   assign busy   = div_busy;
   assign flag_n = flags_q.n;
   assign flag_z = flags_q.z;
   assign flag_c = flags_q.c;
   assign flag_v = flags_q.v;
endmodule

// File: rtl/int_exec_chk.sv
`timescale 1ns/1ps
module int_exec_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic [3:0]   opcode,
   input logic [W-1:0] op_a,
   input logic [W-1:0] op_b,
   input logic         use_imm,
   input logic [W-1:0] result,
   input logic         busy,
   input logic         done,
   input logic         flag_n,
   input logic         flag_z,
   input logic         flag_c,
   input logic         flag_v
);
   logic [31:0] busy_cyc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_cyc <= '0;
      else if (busy) busy_cyc <= busy_cyc + 32'd1;
      else           busy_cyc <= '0;
   end

   // R7
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done);

   // R7
   div_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R7
   div_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(busy)) |-> (busy_cyc == W));

   // R7
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));

   // R11
   flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(start && !busy) |=> $stable({flag_n, flag_z, flag_c, flag_v}));

   // R1
   add_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && opcode == 4'd0 && !use_imm) |=> (result == $past(op_a) + $past(op_b)));
endmodule

bind int_exec_unit int_exec_chk #(.W(WIDTH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .opcode  (opcode),
   .op_a    (op_a),
   .op_b    (op_b),
   .use_imm (use_imm),
   .result  (result),
   .busy    (busy),
   .done    (done),
   .flag_n  (flag_n),
   .flag_z  (flag_z),
   .flag_c  (flag_c),
   .flag_v  (flag_v)
);

// File: tb/int_exec_unit_tb.sv
`timescale 1ns/1ps
module int_exec_unit_tb;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [3:0]   opcode = '0;
   logic [W-1:0] op_a = '0, op_b = '0, op_c = '0, imm = '0;
   logic         use_imm = 1'b0, set_flags = 1'b0;
   logic [W-1:0] result;
   logic         busy, done, flag_n, flag_z, flag_c, flag_v;

   int checks = 0;
   int errors = 0;
   logic [3:0] mflags = 4'b0000; // {n,z,c,v}

   always #4 clk = ~clk;

   int_exec_unit #(.WIDTH(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .op_a(op_a), .op_b(op_b), .op_c(op_c), .imm(imm),
      .use_imm(use_imm), .set_flags(set_flags), .result(result),
      .busy(busy), .done(done), .flag_n(flag_n), .flag_z(flag_z),
      .flag_c(flag_c), .flag_v(flag_v)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [W-1:0] pick(input int k);
      logic [W-1:0] corner [6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFE, 8'hFF};
      if (k < 24) return W'(k * 11);
      return corner[k - 24];
   endfunction

   function automatic logic [W-1:0] model(input int op, input logic [W-1:0] a, b, c);
      logic [15:0] rr;
      case (op)
         0:  return a + b;
         1:  return a - b;
         2:  return a * b;
         3:  return a - b * c;
         4:  return a & b;
         5:  return a | b;
         6:  return a ^ b;
         7:  return a & ~b;
         8:  return a << b[2:0];
         9:  return a >> b[2:0];
         10: begin rr = {a, a} >> b[2:0]; return rr[7:0]; end
         default: return '0;
      endcase
   endfunction

   function automatic logic [W-1:0] sdiv(input logic [W-1:0] a, b);
      int sa, sb, q;
      if (b == 0) return '0;
      sa = int'($signed(a));
      sb = int'($signed(b));
      q  = sa / sb;
      return q[W-1:0];
   endfunction

   task automatic issue(input int op, input logic [W-1:0] a, b, c, im, input logic ui, sf);
      @(negedge clk);
      opcode = 4'(op); op_a = a; op_b = b; op_c = c; imm = im;
      use_imm = ui; set_flags = sf; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic model_flags(input int op, input logic [W-1:0] a, b, r, input logic sf);
      logic [8:0] s;
      if (!sf) return;
      if (op == 0) begin
         s = {1'b0, a} + {1'b0, b};
         mflags = {r[7], r == 0, s[8], (a[7] == b[7]) && (r[7] != a[7])};
      end else if (op == 1) begin
         mflags = {r[7], r == 0, a >= b, (a[7] != b[7]) && (r[7] != a[7])};
      end else if (op == 4) begin
         mflags = {r[7], r == 0, mflags[1], mflags[0]};
      end
   endtask

   task automatic run_fast(input int op, input logic [W-1:0] a, b, c, input logic ui, input logic sf);
      logic [W-1:0] rb, exp;
      string tag;
      rb  = ui ? ~b : b;
      exp = model(op, a, b, c);
      issue(op, a, rb, c, b, ui, sf);
      tag = (op < 2) ? "R1" : (op < 4) ? "R2" : (op < 8) ? "R3" : "R4";
      check("R7 done", 32'(done), 32'd1);
      check(tag, 32'(result), 32'(exp));
      model_flags(op, a, b, exp, sf);
      tag = (sf && (op == 0 || op == 1)) ? "R9 flags" : (sf && op == 4) ? "R10 flags" : "R11 flags";
      check(tag, 32'({flag_n, flag_z, flag_c, flag_v}), 32'(mflags));
   endtask

   task automatic run_div(input int op, input logic [W-1:0] a, b, input logic ui);
      int n;
      logic [W-1:0] exp;
      exp = (op == 11) ? ((b == 0) ? 8'h00 : a / b) : sdiv(a, b);
      issue(op, a, ui ? ~b : b, 8'h00, b, ui, 1'b1);
      check("R7 busy", 32'(busy), 32'd1);
      n = 0;
      while (!done && n < 100) begin
         @(negedge clk);
         n++;
      end
      check("R7 div latency", n, W);
      check((op == 11) ? "R5" : "R6", 32'(result), 32'(exp));
      check("R11 div flags", 32'({flag_n, flag_z, flag_c, flag_v}), 32'(mflags));
      @(negedge clk);
      check("R7 done pulse", 32'(done), 32'd0);
   endtask

   initial begin
      #1600000;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R12
      check("R12 result", 32'(result), 32'd0);
      check("R12 busy", 32'(busy), 32'd0);
      check("R12 done", 32'(done), 32'd0);
      check("R12 flags", 32'({flag_n, flag_z, flag_c, flag_v}), 32'd0);
      rst_n = 1'b1;

      // R5 R6 corners
      run_div(11, 8'd200, 8'd0, 1'b0);
      run_div(12, 8'h80, 8'hFF, 1'b0);
      run_div(12, 8'hF9, 8'd2, 1'b0);
      run_div(12, 8'd7, 8'd0, 1'b1);

      // R8: start during busy is dropped
      @(negedge clk);
      opcode = 4'd11; op_a = 8'd200; op_b = 8'd7; use_imm = 1'b0; set_flags = 1'b0; start = 1'b1;
      @(negedge clk);
      opcode = 4'd0; op_a = 8'h7F; op_b = 8'h01; set_flags = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R8 no done", 32'(done), 32'd0);
      n = 1;
      while (!done && n < 100) begin
         @(negedge clk);
         n++;
      end
      check("R8 latency", n, W);
      check("R8 result", 32'(result), 32'd28);
      check("R8 flags", 32'({flag_n, flag_z, flag_c, flag_v}), 32'(mflags));

      // sweeps
      for (int i = 0; i < 30; i++) begin
         for (int j = 0; j < 30; j++) begin
            for (int op = 0; op < 11; op++) begin
               run_fast(op, pick(i), pick(j), pick(i) ^ pick(j) ^ 8'h35,
                        1'((i + op) & 1), 1'((i ^ j ^ op) & 1));
            end
            run_div(11, pick(i), pick(j), 1'(j & 1));
            run_div(12, pick(i), pick(j), 1'(i & 1));
         end
      end

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule